// File: doc/BRIEF.md
# Domain-Isolated Indirect Branch Target Predictor

This block is a small branch target buffer for indirect jumps and calls. The front end presents a fetch PC together with its security context, and the block answers combinationally with a hit flag and a predicted next-fetch address. That context is an address-space number, a virtual-machine number, a privilege bit and a hardware thread number. When an indirect branch resolves, the back end writes the real target through an update port. The written entry carries the full security context of the branch that trained it. Training done in one context therefore never produces a prediction in another.

The storage is 2-way set associative with 16 sets by default. The set index is taken from the PC bits just above the instruction alignment bits. Every remaining upper PC bit forms the stored tag, so two branches with different addresses never alias.

Software has three controls:
- A per-thread restrict bit. When it is set, that thread's privileged lookups return no prediction, and its privileged updates are discarded.
- A single-cycle barrier that invalidates every entry.
- An isolation mode. While it is on, a thread neither hits on nor overwrites an entry trained by its sibling thread.

Top module: `btb_domain_iso`

## Requirements
- R1: After reset, every lookup misses (`lk_hit`=0, `lk_target`=0).
- R2: After an accepted update, a lookup with the same PC and the same context hits from the next cycle on and returns the trained target. `lk_hit` is 0 whenever `lk_valid` is 0, and `lk_target` is 0 whenever `lk_hit` is 0.
- R3: A lookup whose address-space number or virtual-machine number differs from the entry's misses.
- R4: A lookup whose privilege bit differs from the entry's misses.
- R5: The set index is `pc[ALIGN+IDX_W-1:ALIGN]`, with ALIGN=2 and IDX_W=4 by default. All PC bits above the index are compared. Two PCs with the same index and different upper bits never hit on each other's entry.
- R6: While `ctl_isolate`=1, the thread number must also match for a hit. While `ctl_isolate`=0, an entry trained by either thread hits for both threads.
- R7: While `ctl_restrict[t]`=1, a lookup with `lk_priv`=1 and `lk_tid`=t misses. Lookups from thread t with `lk_priv`=0, and lookups from other threads, are unaffected.
- R8: While `ctl_restrict[t]`=1, an update with `up_priv`=1 and `up_tid`=t is discarded. No later lookup finds it.
- R9: `ctl_barrier`=1 invalidates all entries at the next clock edge. A lookup in the barrier cycle misses. An update in the barrier cycle is discarded.
- R10: An update that misses in its set fills an invalid way first, choosing way 0 before way 1. If both ways are valid, it replaces the least recently written way of the set. Recency is changed only by updates.
- R11: An update that matches an existing entry overwrites that entry in place. With the same rule as a lookup, the lowest matching way is chosen. The entry becomes the most recently written way of its set.
- R12: A lookup in the same cycle as an update sees the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Lookup branch PC |
| lk_asid | input | ASID_W | Lookup address-space number |
| lk_vmid | input | VMID_W | Lookup virtual-machine number |
| lk_priv | input | 1 | Lookup privilege (1 = privileged) |
| lk_tid | input | THR_W | Lookup hardware thread |
| lk_hit | output | 1 | Prediction available |
| lk_target | output | PC_W | Predicted target, 0 on miss |
| up_valid | input | 1 | Resolved-branch training request |
| up_pc | input | PC_W | Resolved branch PC |
| up_asid | input | ASID_W | Training address-space number |
| up_vmid | input | VMID_W | Training virtual-machine number |
| up_priv | input | 1 | Training privilege |
| up_tid | input | THR_W | Training hardware thread |
| up_target | input | PC_W | Resolved target |
| ctl_restrict | input | NTHR | Per-thread privileged restriction |
| ctl_isolate | input | 1 | Thread isolation mode |
| ctl_barrier | input | 1 | Invalidate-all command |

## Verification
Three functions can fall in the same cycle: a lookup, an update and the barrier. In the colliding case, a barrier lands together with both a lookup of a trained branch and an update of a fresh one. The lookup must miss at once, and neither the old nor the fresh entry may be found on the following cycles. A second collision drives a lookup and an update of the same PC in one cycle. It must miss in that cycle and hit in the next. A behavioural model of the sets, refreshed only at clock edges, judges these cases. It also judges a long stretch of random mixed traffic, in which these collisions occur often.

// File: rtl/btb_pkg.sv
package btb_pkg;
    localparam int PC_W   = 32;
    localparam int ASID_W = 8;
    localparam int VMID_W = 8;
    localparam int NTHR   = 2;
    localparam int THR_W  = (NTHR > 1) ? $clog2(NTHR) : 1;
    localparam int WAYS   = 2;

    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic [VMID_W-1:0] vmid;
        logic              priv;
        logic [THR_W-1:0]  tid;
    } dom_t;
endpackage

// File: rtl/btb_tag_cmp.sv
module btb_tag_cmp
    import btb_pkg::*;
#(
    parameter int TAG_W = 26
) (
    input  logic             ent_vld,
    input  logic [TAG_W-1:0] ent_tag,
    input  dom_t             ent_dom,
    input  logic [TAG_W-1:0] req_tag,
    input  dom_t             req_dom,
    input  logic             isolate,
    output logic             match
);
    logic ctx_eq;
    logic thr_eq;

    always_comb begin
        ctx_eq = (ent_dom.asid == req_dom.asid) &&
                 (ent_dom.vmid == req_dom.vmid) &&
                 (ent_dom.priv == req_dom.priv);
        thr_eq = !isolate || (ent_dom.tid == req_dom.tid);
        match  = ent_vld && (ent_tag == req_tag) && ctx_eq && thr_eq;
    end
endmodule

// File: rtl/btb_way_pick.sv
module btb_way_pick
    import btb_pkg::*;
(
    input  logic [WAYS-1:0] hit,
    input  logic [WAYS-1:0] vld,
    input  logic            lru_way,
    output logic            any_hit,
    output logic            hit_way,
    output logic            fill_way
);
    always_comb begin
        any_hit = |hit;
        hit_way = hit[0] ? 1'b0 : 1'b1;
        if (!vld[0])
            fill_way = 1'b0;
        else if (!vld[1])
            fill_way = 1'b1;
        else
            fill_way = lru_way;
    end
endmodule

// File: rtl/btb_domain_iso.sv
module btb_domain_iso
    import btb_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int ALIGN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VMID_W-1:0] lk_vmid,
    input  logic              lk_priv,
    input  logic [THR_W-1:0]  lk_tid,
    output logic              lk_hit,
    output logic [PC_W-1:0]   lk_target,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic [ASID_W-1:0] up_asid,
    input  logic [VMID_W-1:0] up_vmid,
    input  logic              up_priv,
    input  logic [THR_W-1:0]  up_tid,
    input  logic [PC_W-1:0]   up_target,
    input  logic [NTHR-1:0]   ctl_restrict,
    input  logic              ctl_isolate,
    input  logic              ctl_barrier
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = PC_W - IDX_W - ALIGN;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        dom_t             dom;
        logic [PC_W-1:0]  tgt;
    } ent_t;

    typedef struct packed {
        ent_t [SETS-1:0][WAYS-1:0] ent;
        logic [SETS-1:0]           lru;
    } state_t;

    state_t st_q, st_d;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    dom_t             lk_dom, up_dom;
    logic [WAYS-1:0]  lk_match, up_match, lk_vld, up_vld;
    logic             lk_any, lk_way, lk_fill_unused;
    logic             up_any, up_way, up_fill;
    logic             lk_ok, up_ok;
    logic             unused_low;

    assign unused_low = ^{lk_pc[ALIGN-1:0], up_pc[ALIGN-1:0]};

    always_comb begin
        lk_idx = lk_pc[ALIGN+IDX_W-1:ALIGN];
        lk_tag = lk_pc[PC_W-1:ALIGN+IDX_W];
        up_idx = up_pc[ALIGN+IDX_W-1:ALIGN];
        up_tag = up_pc[PC_W-1:ALIGN+IDX_W];
        lk_dom = '{asid: lk_asid, vmid: lk_vmid, priv: lk_priv, tid: lk_tid};
        up_dom = '{asid: up_asid, vmid: up_vmid, priv: up_priv, tid: up_tid};
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign lk_vld[w] = st_q.ent[lk_idx][w].vld;
        assign up_vld[w] = st_q.ent[up_idx][w].vld;

        btb_tag_cmp #(.TAG_W(TAG_W)) u_lk_cmp (
            .ent_vld (st_q.ent[lk_idx][w].vld),
            .ent_tag (st_q.ent[lk_idx][w].tag),
            .ent_dom (st_q.ent[lk_idx][w].dom),
            .req_tag (lk_tag),
            .req_dom (lk_dom),
            .isolate (ctl_isolate),
            .match   (lk_match[w])
        );

        btb_tag_cmp #(.TAG_W(TAG_W)) u_up_cmp (
            .ent_vld (st_q.ent[up_idx][w].vld),
            .ent_tag (st_q.ent[up_idx][w].tag),
            .ent_dom (st_q.ent[up_idx][w].dom),
            .req_tag (up_tag),
            .req_dom (up_dom),
            .isolate (ctl_isolate),
            .match   (up_match[w])
        );
    end

    btb_way_pick u_lk_pick (
        .hit      (lk_match),
        .vld      (lk_vld),
        .lru_way  (st_q.lru[lk_idx]),
        .any_hit  (lk_any),
        .hit_way  (lk_way),
        .fill_way (lk_fill_unused)
    );

    btb_way_pick u_up_pick (
        .hit      (up_match),
        .vld      (up_vld),
        .lru_way  (st_q.lru[up_idx]),
        .any_hit  (up_any),
        .hit_way  (up_way),
        .fill_way (up_fill)
    );

    // Lookup side: gated by barrier and privileged restriction.
    always_comb begin
        lk_ok     = lk_valid && !ctl_barrier && !(lk_priv && ctl_restrict[lk_tid]);
        lk_hit    = lk_ok && lk_any;
        lk_target = lk_hit ? st_q.ent[lk_idx][lk_way].tgt : '0;
    end

    // Next-state process.
    always_comb begin
        logic wway;
        st_d  = st_q;
        up_ok = up_valid && !ctl_barrier && !(up_priv && ctl_restrict[up_tid]);
        wway  = up_any ? up_way : up_fill;
        if (ctl_barrier) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    st_d.ent[s][w].vld = 1'b0;
                end
            end
        end else if (up_ok) begin
            st_d.ent[up_idx][wway].vld = 1'b1;
            st_d.ent[up_idx][wway].tag = up_tag;
            st_d.ent[up_idx][wway].dom = up_dom;
            st_d.ent[up_idx][wway].tgt = up_target;
            st_d.lru[up_idx]           = ~wway;
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/btb_domain_iso_chk.sv
module btb_domain_iso_chk
    import btb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [PC_W-1:0]   lk_pc,
    input logic [ASID_W-1:0] lk_asid,
    input logic [VMID_W-1:0] lk_vmid,
    input logic              lk_priv,
    input logic [THR_W-1:0]  lk_tid,
    input logic              lk_hit,
    input logic [PC_W-1:0]   lk_target,
    input logic              up_valid,
    input logic [PC_W-1:0]   up_pc,
    input logic [ASID_W-1:0] up_asid,
    input logic [VMID_W-1:0] up_vmid,
    input logic              up_priv,
    input logic [THR_W-1:0]  up_tid,
    input logic [PC_W-1:0]   up_target,
    input logic [NTHR-1:0]   ctl_restrict,
    input logic              ctl_isolate,
    input logic              ctl_barrier
);
    logic up_acc, lk_acc, past_ok;

    assign up_acc = up_valid && !ctl_barrier && !(up_priv && ctl_restrict[up_tid]);
    assign lk_acc = lk_valid && !ctl_barrier && !(lk_priv && ctl_restrict[lk_tid]);

    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    p_no_target_on_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_target == '0));

    p_hit_needs_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_valid);

    p_barrier_same_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_barrier |-> !lk_hit);

    p_barrier_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_barrier |=> !lk_hit);

    p_restrict_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_priv && ctl_restrict[lk_tid]) |-> !lk_hit);

    p_train_then_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_acc && past_ok) |=>
            (!(lk_acc && lk_pc == $past(up_pc) && lk_asid == $past(up_asid) &&
               lk_vmid == $past(up_vmid) && lk_priv == $past(up_priv) &&
               lk_tid == $past(up_tid) && ctl_isolate == $past(ctl_isolate)) ||
             (lk_hit && lk_target == $past(up_target))));
endmodule

bind btb_domain_iso btb_domain_iso_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_pc        (lk_pc),
    .lk_asid      (lk_asid),
    .lk_vmid      (lk_vmid),
    .lk_priv      (lk_priv),
    .lk_tid       (lk_tid),
    .lk_hit       (lk_hit),
    .lk_target    (lk_target),
    .up_valid     (up_valid),
    .up_pc        (up_pc),
    .up_asid      (up_asid),
    .up_vmid      (up_vmid),
    .up_priv      (up_priv),
    .up_tid       (up_tid),
    .up_target    (up_target),
    .ctl_restrict (ctl_restrict),
    .ctl_isolate  (ctl_isolate),
    .ctl_barrier  (ctl_barrier)
);

// File: tb/btb_domain_iso_tb.sv
module btb_domain_iso_tb;
    import btb_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [PC_W-1:0]   lk_pc = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic [VMID_W-1:0] lk_vmid = '0;
    logic              lk_priv = 1'b0;
    logic [THR_W-1:0]  lk_tid = '0;
    logic              lk_hit;
    logic [PC_W-1:0]   lk_target;
    logic              up_valid = 1'b0;
    logic [PC_W-1:0]   up_pc = '0;
    logic [ASID_W-1:0] up_asid = '0;
    logic [VMID_W-1:0] up_vmid = '0;
    logic              up_priv = 1'b0;
    logic [THR_W-1:0]  up_tid = '0;
    logic [PC_W-1:0]   up_target = '0;
    logic [NTHR-1:0]   ctl_restrict = '0;
    logic              ctl_isolate = 1'b0;
    logic              ctl_barrier = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    btb_domain_iso u_dut (.*);

    // Behavioural reference: per set, two slots plus "which slot to evict".
    bit          m_v   [16][2];
    logic [31:0] m_pc  [16][2];
    logic [7:0]  m_as  [16][2];
    logic [7:0]  m_vm  [16][2];
    bit          m_pr  [16][2];
    bit          m_th  [16][2];
    logic [31:0] m_tg  [16][2];
    int          m_old [16];

    function automatic int set_of(logic [31:0] pc);
        return int'(pc[5:2]);
    endfunction

    function automatic bit same(int s, int w, logic [31:0] pc, logic [7:0] a,
                                logic [7:0] v, bit p, bit t, bit iso);
        if (!m_v[s][w]) return 0;
        if (m_pc[s][w][31:6] != pc[31:6]) return 0;
        if (m_as[s][w] != a || m_vm[s][w] != v || m_pr[s][w] != p) return 0;
        if (iso && m_th[s][w] != t) return 0;
        return 1;
    endfunction

    task automatic model_lookup(output bit h, output logic [31:0] t);
        int s;
        h = 0;
        t = 0;
        if (!lk_valid || ctl_barrier || (lk_priv && ctl_restrict[lk_tid])) return;
        s = set_of(lk_pc);
        for (int w = 0; w < 2; w++) begin
            if (!h && same(s, w, lk_pc, lk_asid, lk_vmid, lk_priv, lk_tid, ctl_isolate)) begin
                h = 1;
                t = m_tg[s][w];
            end
        end
    endtask

    task automatic model_clock();
        int s, w;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                m_v[i][0] = 0; m_v[i][1] = 0; m_old[i] = 0;
            end
            return;
        end
        if (ctl_barrier) begin
            for (int i = 0; i < 16; i++) begin
                m_v[i][0] = 0; m_v[i][1] = 0;
            end
            return;
        end
        if (!up_valid || (up_priv && ctl_restrict[up_tid])) return;
        s = set_of(up_pc);
        w = -1;
        for (int k = 0; k < 2; k++)
            if (w < 0 && same(s, k, up_pc, up_asid, up_vmid, up_priv, up_tid, ctl_isolate)) w = k;
        if (w < 0) begin
            if (!m_v[s][0]) w = 0;
            else if (!m_v[s][1]) w = 1;
            else w = m_old[s];
        end
        m_v[s][w] = 1;
        m_pc[s][w] = up_pc;
        m_as[s][w] = up_asid;
        m_vm[s][w] = up_vmid;
        m_pr[s][w] = up_priv;
        m_th[s][w] = up_tid;
        m_tg[s][w] = up_target;
        m_old[s] = 1 - w;
    endtask

    task automatic step(input string req, input bit dir, input bit eh, input logic [31:0] et);
        bit mh;
        logic [31:0] mt;
        @(negedge clk);
        if (rst_n) begin
            model_lookup(mh, mt);
            n_chk++;
            if (lk_hit !== mh || lk_target !== mt) begin
                n_fail++;
                $display("FAIL %s model: hit=%0b tgt=%h expected hit=%0b tgt=%h",
                         req, lk_hit, lk_target, mh, mt);
            end
        end
        if (dir) begin
            n_chk++;
            if (lk_hit !== eh || lk_target !== et) begin
                n_fail++;
                $display("FAIL %s directed: hit=%0b tgt=%h expected hit=%0b tgt=%h",
                         req, lk_hit, lk_target, eh, et);
            end
        end
        @(posedge clk);
        model_clock();
        #1;
    endtask

    task automatic set_up(input logic [31:0] pc, input logic [31:0] tg, input logic [7:0] a,
                          input logic [7:0] v, input bit p, input bit t);
        up_valid = 1; up_pc = pc; up_target = tg;
        up_asid = a; up_vmid = v; up_priv = p; up_tid = t;
    endtask

    task automatic set_lk(input logic [31:0] pc, input logic [7:0] a, input logic [7:0] v,
                          input bit p, input bit t);
        lk_valid = 1; lk_pc = pc; lk_asid = a; lk_vmid = v; lk_priv = p; lk_tid = t;
    endtask

    task automatic upd(input string req, input logic [31:0] pc, input logic [31:0] tg,
                       input logic [7:0] a, input logic [7:0] v, input bit p, input bit t);
        set_up(pc, tg, a, v, p, t);
        step(req, 0, 0, 0);
        up_valid = 0;
    endtask

    task automatic look(input string req, input logic [31:0] pc, input logic [7:0] a,
                        input logic [7:0] v, input bit p, input bit t,
                        input bit eh, input logic [31:0] et);
        set_lk(pc, a, v, p, t);
        step(req, 1, eh, et);
        lk_valid = 0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        for (int i = 0; i < 3; i++) step("R1", 0, 0, 0);
        rst_n = 1;
        // R1: empty after reset
        look("R1", 32'h0000_1004, 8'd3, 8'd1, 0, 0, 0, 0);
        look("R1", 32'h0000_2008, 8'd3, 8'd1, 1, 1, 0, 0);

        // R2: train and hit; no request means no hit
        upd("R2", 32'h0000_1004, 32'hAAAA_0000, 8'd3, 8'd1, 0, 0);
        look("R2", 32'h0000_1004, 8'd3, 8'd1, 0, 0, 1, 32'hAAAA_0000);
        lk_pc = 32'h0000_1004;
        step("R2", 1, 0, 0);

        // R3 / R4: context mismatches
        look("R3", 32'h0000_1004, 8'd4, 8'd1, 0, 0, 0, 0);
        look("R3", 32'h0000_1004, 8'd3, 8'd2, 0, 0, 0, 0);
        look("R4", 32'h0000_1004, 8'd3, 8'd1, 1, 0, 0, 0);

        // R5: same index, different upper bits
        look("R5", 32'h0001_1004, 8'd3, 8'd1, 0, 0, 0, 0);
        look("R5", 32'h0000_1084, 8'd3, 8'd1, 0, 0, 0, 0);

        // R6: thread isolation
        ctl_isolate = 0;
        look("R6", 32'h0000_1004, 8'd3, 8'd1, 0, 1, 1, 32'hAAAA_0000);
        ctl_isolate = 1;
        look("R6", 32'h0000_1004, 8'd3, 8'd1, 0, 1, 0, 0);
        look("R6", 32'h0000_1004, 8'd3, 8'd1, 0, 0, 1, 32'hAAAA_0000);
        ctl_isolate = 0;

        // R7: restriction in privileged mode
        upd("R7", 32'h0000_2008, 32'hBBBB_0000, 8'd3, 8'd1, 1, 0);
        look("R7", 32'h0000_2008, 8'd3, 8'd1, 1, 0, 1, 32'hBBBB_0000);
        ctl_restrict = 2'b01;
        look("R7", 32'h0000_2008, 8'd3, 8'd1, 1, 0, 0, 0);
        look("R7", 32'h0000_1004, 8'd3, 8'd1, 0, 0, 1, 32'hAAAA_0000);
        look("R7", 32'h0000_2008, 8'd3, 8'd1, 1, 1, 1, 32'hBBBB_0000);

        // R8: restricted privileged training is dropped
        upd("R8", 32'h0000_300C, 32'hCCCC_0000, 8'd3, 8'd1, 1, 0);
        upd("R8", 32'h0000_3010, 32'hCCCC_1000, 8'd3, 8'd1, 0, 0);
        ctl_restrict = 2'b00;
        look("R8", 32'h0000_300C, 8'd3, 8'd1, 1, 0, 0, 0);
        look("R8", 32'h0000_3010, 8'd3, 8'd1, 0, 0, 1, 32'hCCCC_1000);

        // R12: lookup alongside update of the same branch
        set_up(32'h0000_4014, 32'hEEEE_0000, 8'd3, 8'd1, 0, 0);
        set_lk(32'h0000_4014, 8'd3, 8'd1, 0, 0);
        step("R12", 1, 0, 0);
        up_valid = 0;
        step("R12", 1, 1, 32'hEEEE_0000);
        lk_valid = 0;

        // R11: in-place overwrite
        upd("R11", 32'h0000_1004, 32'hDDDD_0000, 8'd3, 8'd1, 0, 0);
        look("R11", 32'h0000_1004, 8'd3, 8'd1, 0, 0, 1, 32'hDDDD_0000);

        // R10: replacement in set 6 (pc[5:2]=6 for 0x..18)
        upd("R10", 32'h0000_5018, 32'h5555_0000, 8'd3, 8'd1, 0, 0);
        upd("R10", 32'h0000_6018, 32'h6666_0000, 8'd3, 8'd1, 0, 0);
        upd("R10", 32'h0000_7018, 32'h7777_0000, 8'd3, 8'd1, 0, 0);
        look("R10", 32'h0000_5018, 8'd3, 8'd1, 0, 0, 0, 0);
        look("R10", 32'h0000_6018, 8'd3, 8'd1, 0, 0, 1, 32'h6666_0000);
        look("R10", 32'h0000_7018, 8'd3, 8'd1, 0, 0, 1, 32'h7777_0000);
        upd("R11", 32'h0000_6018, 32'h6666_1000, 8'd3, 8'd1, 0, 0);
        upd("R10", 32'h0000_8018, 32'h8888_0000, 8'd3, 8'd1, 0, 0);
        look("R10", 32'h0000_7018, 8'd3, 8'd1, 0, 0, 0, 0);
        look("R11", 32'h0000_6018, 8'd3, 8'd1, 0, 0, 1, 32'h6666_1000);
        look("R10", 32'h0000_8018, 8'd3, 8'd1, 0, 0, 1, 32'h8888_0000);

        // R9: barrier together with lookup and update
        ctl_barrier = 1;
        set_up(32'h0000_9020, 32'h9999_0000, 8'd3, 8'd1, 0, 0);
        set_lk(32'h0000_6018, 8'd3, 8'd1, 0, 0);
        step("R9", 1, 0, 0);
        ctl_barrier = 0;
        up_valid = 0;
        lk_valid = 0;
        look("R9", 32'h0000_6018, 8'd3, 8'd1, 0, 0, 0, 0);
        look("R9", 32'h0000_9020, 8'd3, 8'd1, 0, 0, 0, 0);
        look("R9", 32'h0000_1004, 8'd3, 8'd1, 0, 0, 0, 0);
        look("R9", 32'h0000_4014, 8'd3, 8'd1, 0, 0, 0, 0);

        // Mixed random traffic judged by the model
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] pool [6];
            pool[0] = 32'h0000_1004; pool[1] = 32'h0000_2004; pool[2] = 32'h0000_3004;
            pool[3] = 32'h0000_1008; pool[4] = 32'h0001_1004; pool[5] = 32'h0000_2008;
            lk_valid = 1'($urandom);
            lk_pc = pool[$urandom % 6];
            lk_asid = 8'(3 + ($urandom % 2)); lk_vmid = 8'd1;
            lk_priv = 1'($urandom); lk_tid = 1'($urandom);
            up_valid = 1'($urandom);
            up_pc = pool[$urandom % 6];
            up_target = $urandom;
            up_asid = 8'(3 + ($urandom % 2)); up_vmid = 8'd1;
            up_priv = 1'($urandom); up_tid = 1'($urandom);
            ctl_restrict = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
            ctl_isolate = 1'($urandom);
            ctl_barrier = (($urandom % 40) == 0);
            step("R12", 0, 0, 0);
        end
        lk_valid = 0; up_valid = 0; ctl_barrier = 0;

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule